// File: doc/BRIEF.md
# Dual-Issue Instruction Word Dispatcher

This block turns each fetched 32-bit instruction word into an ordered series of slot issues for the execution units. A word holds either one 30-bit long instruction or two 15-bit short instructions, a left one and a right one. A two-bit format field in the top bits selects one of four ways to issue them: long, sequential with the right slot first, sequential with the left slot first, or a parallel pair. The execution units report back in the same cycle as each issue. They say whether the issued instruction redirected the PC, where it went, and, for a test-only opcode, whether the tested condition held. The dispatcher uses these answers to decide whether the other slot still issues.

When the word is finished, the block works out the next PC. A pending branch, the hardware repeat loop and the debug breakpoint trap are resolved in a fixed priority order. The result comes out with a one-cycle `done_o` pulse, together with the repeat-count update and the status word to write back. Three free-running event counters record fetched cycles, second halves skipped because of a branch, and conditional partners suppressed by a false test. Opcode classification is supplied from outside for each word: test-only flags and unknown-opcode flags for each slot. The loop, breakpoint and status inputs must stay stable while a word is in flight.

Top module: `dual_issue_dispatch`

## Requirements
- R1: Format 00 issues exactly one long instruction. Its payload is word bits 29:0 and `issue_long_o` is 1.
- R2: The left short instruction is word bits 29:15 and the right one is bits 14:0, each zero-extended on `issue_insn_o`. Format 01 issues right then left, and format 10 issues left then right. `issue_right_o` is 1 for a right-slot issue.
- R3: In a sequential format, the second slot issues only if the first did not report a branch. Otherwise the second slot is dropped and the skip counter grows by one.
- R4: In format 11 with the left slot test-only, the left slot issues first. The right slot issues in the next cycle only if `ex_cond_i` was 1 during the left issue. Otherwise the condition-false counter grows by one.
- R5: In format 11 with only the right slot test-only, the right slot issues first and the left slot is conditional on it. When both slots are test-only, the left slot is treated as the test.
- R6: In format 11 with no test-only slot, left then right both issue, whether or not the left one branches.
- R7: If any issued slot reported a branch, the next PC is the target of the last such slot. Otherwise it is the word's PC plus one, wrapping at the PC width.
- R8: With no branch, repeat enabled and PC equal to the loop end, the next PC is the loop start, `loop_o` is 1 and `rpt_cnt_o` is the count minus one. A branch taken at the loop end wins over the loop.
- R9: With debug enabled and PC equal to the breakpoint address, the next PC is the trap vector (default 0xFFF4) and `trap_o` is 1. `psw_o` is the status word with only bit 15 kept. This overrides any branch and the loop.
- R10: The cycle counter grows by one for each accepted word and by one more when the second half of a sequential pair issues.
- R11: A slot flagged unknown is not issued, and no later slot of that word is issued. In format 11 a flag on either slot stops both; format 00 uses the left flag. The word ends with `illegal_o`, the next PC equals its own PC, and there is no loop or trap.
- R12: `ready_o` is 1 only when idle. The first issue appears in the cycle after a word is accepted, a second issue appears in the cycle after that, and `done_o` appears in the cycle after the last issue state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Instruction word offered |
| word_i | input | 32 | Fetched instruction word |
| pc_i | input | PC_W | PC of the offered word |
| ready_o | output | 1 | Dispatcher idle, word accepted when valid |
| l_test_i | input | 1 | Left slot is a test-only opcode |
| r_test_i | input | 1 | Right slot is a test-only opcode |
| l_bad_i | input | 1 | Left slot (or long) opcode unknown |
| r_bad_i | input | 1 | Right slot opcode unknown |
| issue_valid_o | output | 1 | A slot is issued this cycle |
| issue_long_o | output | 1 | The issued slot is a long instruction |
| issue_right_o | output | 1 | The issued slot is the right one |
| issue_insn_o | output | 30 | Issued instruction bits |
| ex_branch_i | input | 1 | Issued instruction changed the PC |
| ex_target_i | input | PC_W | Branch target of the issued instruction |
| ex_cond_i | input | 1 | Condition result of an issued test |
| rpt_en_i | input | 1 | Repeat loop active |
| rpt_start_i | input | PC_W | Loop start PC |
| rpt_end_i | input | PC_W | Loop end PC |
| rpt_cnt_i | input | PC_W | Remaining repeat count |
| dbg_en_i | input | 1 | Debug breakpoint enabled |
| bp_addr_i | input | PC_W | Breakpoint PC |
| psw_i | input | PSW_W | Current status word |
| done_o | output | 1 | Word finished, results valid |
| illegal_o | output | 1 | Word ended on an unknown opcode |
| next_pc_o | output | PC_W | PC of the next word |
| loop_o | output | 1 | Loop-back taken |
| rpt_cnt_o | output | PC_W | Updated repeat count |
| trap_o | output | 1 | Breakpoint trap taken |
| psw_o | output | PSW_W | Status word to write back |
| cyc_cnt_o | output | CNT_W | Cycle event counter |
| skip_cnt_o | output | CNT_W | Skipped-by-branch counter |
| cfalse_cnt_o | output | CNT_W | Condition-false counter |

## Verification
Once a word is accepted, the first slot shows on the issue outputs one cycle later. The execution feedback for that slot is sampled at the edge that closes that cycle, so any second slot appears one cycle after the first, and `done_o` with the next PC and counter updates follows one cycle after the last issue state. The bench samples every output at the falling edge. It answers each issue with feedback driven at that same falling edge and counts falling edges from acceptance, expecting `done_o` at the second or third one depending on whether a second issue state is entered. The counters are compared at the `done_o` edge, by which point every event of the word has landed.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int WORD_W  = 32;
  localparam int SHORT_W = 15;
  localparam int BODY_W  = 30;

  typedef enum logic [1:0] {
    FMT_LONG = 2'b00,
    FMT_RL   = 2'b01,
    FMT_LR   = 2'b10,
    FMT_PAR  = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ONE,
    ST_TWO,
    ST_END
  } st_e;

  localparam int EV_CYC    = 0;
  localparam int EV_SKIP   = 1;
  localparam int EV_CFALSE = 2;
  localparam int EV_N      = 3;
endpackage

// File: rtl/dsp_word_split.sv
module dsp_word_split
  import dsp_pkg::*;
(
  input  logic [BODY_W-1:0]  body_i,
  output logic [SHORT_W-1:0] l_slot_o,
  output logic [SHORT_W-1:0] r_slot_o
);
  assign l_slot_o = body_i[2*SHORT_W-1:SHORT_W];
  assign r_slot_o = body_i[SHORT_W-1:0];
endmodule

// File: rtl/dsp_issue_seq.sv
module dsp_issue_seq
  import dsp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            word_valid_i,
  input  fmt_e            fmt_i,
  input  logic            l_test_i,
  input  logic            r_test_i,
  input  logic            l_bad_i,
  input  logic            r_bad_i,
  input  logic            ex_branch_i,
  input  logic            ex_cond_i,
  output logic            ready_o,
  output logic            accept_o,
  output logic            issue_valid_o,
  output logic            issue_long_o,
  output logic            issue_right_o,
  output logic            end_o,
  output logic            illegal_o,
  output logic [EV_N-1:0] ev_o
);
  st_e  st_q, st_d;
  fmt_e fmt_q;
  logic lt_q, rt_q, lb_q, rb_q;
  logic ill_q, ill_d;
  logic is_seq, is_test, first_right, first_bad, second_bad;
  logic in_one, in_two;

  always_comb begin
    is_seq      = (fmt_q == FMT_RL) || (fmt_q == FMT_LR);
    is_test     = (fmt_q == FMT_PAR) && (lt_q || rt_q);
    // left test wins when both slots are test-only
    first_right = (fmt_q == FMT_RL) || ((fmt_q == FMT_PAR) && !lt_q && rt_q);
    first_bad   = (fmt_q == FMT_PAR) ? (lb_q || rb_q) : (first_right ? rb_q : lb_q);
    second_bad  = first_right ? lb_q : rb_q;
    in_one      = (st_q == ST_ONE);
    in_two      = (st_q == ST_TWO);
  end

  assign ready_o       = (st_q == ST_IDLE);
  assign accept_o      = ready_o && word_valid_i;
  assign issue_valid_o = (in_one && !first_bad) || (in_two && !second_bad);
  assign issue_long_o  = issue_valid_o && (fmt_q == FMT_LONG);
  assign issue_right_o = issue_valid_o && !issue_long_o && (in_one ? first_right : !first_right);
  assign end_o         = (st_q == ST_END);
  assign illegal_o     = end_o && ill_q;

  always_comb begin
    st_d  = st_q;
    ill_d = ill_q;
    unique case (st_q)
      ST_IDLE: if (word_valid_i) begin
        st_d  = ST_ONE;
        ill_d = 1'b0;
      end
      ST_ONE: begin
        st_d = ST_END;
        if (first_bad)               ill_d = 1'b1;
        else if (is_seq)  begin if (!ex_branch_i) st_d = ST_TWO; end
        else if (is_test) begin if (ex_cond_i)    st_d = ST_TWO; end
        else if (fmt_q == FMT_PAR)   st_d = ST_TWO;
      end
      ST_TWO: begin
        st_d = ST_END;
        if (second_bad) ill_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ev_o            = '0;
    ev_o[EV_CYC]    = accept_o || (in_two && is_seq && !second_bad);
    ev_o[EV_SKIP]   = in_one && !first_bad && is_seq && ex_branch_i;
    ev_o[EV_CFALSE] = in_one && !first_bad && is_test && !ex_cond_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ill_q <= 1'b0;
      fmt_q <= FMT_LONG;
      lt_q  <= 1'b0;
      rt_q  <= 1'b0;
      lb_q  <= 1'b0;
      rb_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ill_q <= ill_d;
      if (accept_o) begin
        fmt_q <= fmt_i;
        lt_q  <= l_test_i;
        rt_q  <= r_test_i;
        lb_q  <= l_bad_i;
        rb_q  <= r_bad_i;
      end
    end
  end

  assert_long_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_long_o) |=> (!issue_valid_o && end_o));

  assert_seq_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_one && issue_valid_o && is_seq && ex_branch_i) |=> (end_o && !issue_valid_o));

  assert_cond_false_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_one && issue_valid_o && is_test && !ex_cond_i) |=> (end_o && !issue_valid_o));

  assert_par_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_one && issue_valid_o && (fmt_q == FMT_PAR) && !is_test)
      |=> (issue_valid_o && issue_right_o));

  assert_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !ready_o);

  assert_accept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> in_one);

  assert_end_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> ready_o);
endmodule

// File: rtl/dsp_pc_resolve.sv
module dsp_pc_resolve #(
  parameter int unsigned     PC_W     = 16,
  parameter int unsigned     PSW_W    = 16,
  parameter int unsigned     SM_BIT   = 15,
  parameter logic [PC_W-1:0] TRAP_VEC = PC_W'(32'hFFF4)
) (
  input  logic             end_i,
  input  logic             illegal_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             branched_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic             rpt_en_i,
  input  logic [PC_W-1:0]  rpt_start_i,
  input  logic [PC_W-1:0]  rpt_end_i,
  input  logic [PC_W-1:0]  rpt_cnt_i,
  input  logic             dbg_en_i,
  input  logic [PC_W-1:0]  bp_addr_i,
  input  logic [PSW_W-1:0] psw_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             loop_o,
  output logic             trap_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [PC_W-1:0]  rpt_cnt_o
);
  localparam logic [PSW_W-1:0] SM_MASK = PSW_W'(1) << SM_BIT;

  logic live;

  always_comb begin
    live   = end_i && !illegal_i;
    trap_o = live && dbg_en_i && (pc_i == bp_addr_i);
    // a branch at the loop end is taken instead of the loop
    loop_o = live && !trap_o && !branched_i && rpt_en_i && (pc_i == rpt_end_i);
    if (illegal_i)       next_pc_o = pc_i;
    else if (trap_o)     next_pc_o = TRAP_VEC;
    else if (branched_i) next_pc_o = target_i;
    else if (loop_o)     next_pc_o = rpt_start_i;
    else                 next_pc_o = pc_i + PC_W'(1);
    psw_o     = trap_o ? (psw_i & SM_MASK) : psw_i;
    rpt_cnt_o = loop_o ? (rpt_cnt_i - PC_W'(1)) : rpt_cnt_i;
  end
endmodule

// File: rtl/dsp_event_cnt.sv
module dsp_event_cnt #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        ev_i,
  output logic [N-1:0][W-1:0] cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (ev_i[g]) cnt_q <= cnt_q + W'(1);
    end
    assign cnt_o[g] = cnt_q;
  end
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dsp_pkg::*;
#(
  parameter int unsigned     PC_W     = 16,
  parameter int unsigned     PSW_W    = 16,
  parameter int unsigned     SM_BIT   = 15,
  parameter int unsigned     CNT_W    = 16,
  parameter logic [PC_W-1:0] TRAP_VEC = PC_W'(32'hFFF4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              ready_o,
  input  logic              l_test_i,
  input  logic              r_test_i,
  input  logic              l_bad_i,
  input  logic              r_bad_i,
  output logic              issue_valid_o,
  output logic              issue_long_o,
  output logic              issue_right_o,
  output logic [29:0]       issue_insn_o,
  input  logic              ex_branch_i,
  input  logic [PC_W-1:0]   ex_target_i,
  input  logic              ex_cond_i,
  input  logic              rpt_en_i,
  input  logic [PC_W-1:0]   rpt_start_i,
  input  logic [PC_W-1:0]   rpt_end_i,
  input  logic [PC_W-1:0]   rpt_cnt_i,
  input  logic              dbg_en_i,
  input  logic [PC_W-1:0]   bp_addr_i,
  input  logic [PSW_W-1:0]  psw_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              loop_o,
  output logic [PC_W-1:0]   rpt_cnt_o,
  output logic              trap_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic [CNT_W-1:0]  cyc_cnt_o,
  output logic [CNT_W-1:0]  skip_cnt_o,
  output logic [CNT_W-1:0]  cfalse_cnt_o
);
  logic                         accept;
  logic [EV_N-1:0]              ev;
  logic [EV_N-1:0][CNT_W-1:0]   cnt;
  logic [BODY_W-1:0]            body_q;
  logic [PC_W-1:0]              pc_q;
  logic                         br_q;
  logic [PC_W-1:0]              tgt_q;
  logic [SHORT_W-1:0]           l_slot, r_slot;

  dsp_issue_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .word_valid_i  (word_valid_i),
    .fmt_i         (fmt_e'(word_i[WORD_W-1:BODY_W])),
    .l_test_i      (l_test_i),
    .r_test_i      (r_test_i),
    .l_bad_i       (l_bad_i),
    .r_bad_i       (r_bad_i),
    .ex_branch_i   (ex_branch_i),
    .ex_cond_i     (ex_cond_i),
    .ready_o       (ready_o),
    .accept_o      (accept),
    .issue_valid_o (issue_valid_o),
    .issue_long_o  (issue_long_o),
    .issue_right_o (issue_right_o),
    .end_o         (done_o),
    .illegal_o     (illegal_o),
    .ev_o          (ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      body_q <= '0;
      pc_q   <= '0;
      br_q   <= 1'b0;
      tgt_q  <= '0;
    end else if (accept) begin
      body_q <= word_i[BODY_W-1:0];
      pc_q   <= pc_i;
      br_q   <= 1'b0;
      tgt_q  <= '0;
    end else if (issue_valid_o && ex_branch_i) begin
      br_q   <= 1'b1;
      tgt_q  <= ex_target_i;
    end
  end

  dsp_word_split u_split (
    .body_i   (body_q),
    .l_slot_o (l_slot),
    .r_slot_o (r_slot)
  );

  always_comb begin
    if (!issue_valid_o)    issue_insn_o = '0;
    else if (issue_long_o) issue_insn_o = body_q;
    else                   issue_insn_o = {{(BODY_W-SHORT_W){1'b0}}, (issue_right_o ? r_slot : l_slot)};
  end

  dsp_pc_resolve #(
    .PC_W     (PC_W),
    .PSW_W    (PSW_W),
    .SM_BIT   (SM_BIT),
    .TRAP_VEC (TRAP_VEC)
  ) u_pc (
    .end_i       (done_o),
    .illegal_i   (illegal_o),
    .pc_i        (pc_q),
    .branched_i  (br_q),
    .target_i    (tgt_q),
    .rpt_en_i    (rpt_en_i),
    .rpt_start_i (rpt_start_i),
    .rpt_end_i   (rpt_end_i),
    .rpt_cnt_i   (rpt_cnt_i),
    .dbg_en_i    (dbg_en_i),
    .bp_addr_i   (bp_addr_i),
    .psw_i       (psw_i),
    .next_pc_o   (next_pc_o),
    .loop_o      (loop_o),
    .trap_o      (trap_o),
    .psw_o       (psw_o),
    .rpt_cnt_o   (rpt_cnt_o)
  );

  dsp_event_cnt #(.N(EV_N), .W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .cnt_o  (cnt)
  );

  assign cyc_cnt_o    = cnt[EV_CYC];
  assign skip_cnt_o   = cnt[EV_SKIP];
  assign cfalse_cnt_o = cnt[EV_CFALSE];

  assert_loop_only_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_o |-> (done_o && !trap_o && !illegal_o));

  assert_trap_vector_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (next_pc_o == TRAP_VEC && !loop_o && done_o));

  assert_cyc_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_cnt_o != $past(cyc_cnt_o)) |-> (cyc_cnt_o == $past(cyc_cnt_o) + CNT_W'(1)));

  assert_illegal_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (next_pc_o == pc_q && !loop_o && !trap_o));

  assert_illegal_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !issue_valid_o);
endmodule

// File: tb/dual_issue_dispatch_tb.sv
`timescale 1ns/1ps
module dual_issue_dispatch_tb;
  localparam logic [15:0] TRAP_VEC = 16'hFFF4;
  localparam logic [15:0] SM_MASK  = 16'h8000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        word_valid_i = 0;
  logic [31:0] word_i = '0;
  logic [15:0] pc_i = '0;
  logic        ready_o;
  logic        l_test_i = 0, r_test_i = 0, l_bad_i = 0, r_bad_i = 0;
  logic        issue_valid_o, issue_long_o, issue_right_o;
  logic [29:0] issue_insn_o;
  logic        ex_branch_i = 0;
  logic [15:0] ex_target_i = '0;
  logic        ex_cond_i = 0;
  logic        rpt_en_i = 0;
  logic [15:0] rpt_start_i = '0, rpt_end_i = '0, rpt_cnt_i = '0;
  logic        dbg_en_i = 0;
  logic [15:0] bp_addr_i = '0, psw_i = '0;
  logic        done_o, illegal_o, loop_o, trap_o;
  logic [15:0] next_pc_o, rpt_cnt_o, psw_o;
  logic [15:0] cyc_cnt_o, skip_cnt_o, cfalse_cnt_o;

  dual_issue_dispatch u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [15:0] x_cyc = '0, x_skip = '0, x_cf = '0;

  typedef struct {
    logic [31:0] w;
    logic lt, rt, lb, rb, lbr, rbr, lc, rc, ren, den;
    logic [15:0] ltg, rtg, pc, rs, re, rcnt, bp, psw;
  } stim_t;

  int          e_n;
  logic [1:0]  e_code [2];
  logic [29:0] e_pay [2];
  bit          e_ill, e_two, e_br, e_loop, e_trap;
  logic [15:0] e_tgt, e_npc, e_psw, e_rcnt;
  int          e_dcyc, e_dsk, e_dcf;
  string       e_req, e_preq;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] pay_of(stim_t s, logic [1:0] c);
    if (c == 2'd2) return s.w[29:0];
    if (c == 2'd1) return {15'b0, s.w[14:0]};
    return {15'b0, s.w[29:15]};
  endfunction

  task automatic m_issue(stim_t s, bit right, bit lng);
    logic [1:0] c;
    c = lng ? 2'd2 : (right ? 2'd1 : 2'd0);
    e_code[e_n] = c;
    e_pay[e_n]  = pay_of(s, c);
    e_n++;
    if (right ? s.rbr : s.lbr) begin
      e_br  = 1;
      e_tgt = right ? s.rtg : s.ltg;
    end
  endtask

  task automatic model(stim_t s);
    bit fr, fbad, fbr, sbad;
    e_n = 0; e_code[0] = 2'd3; e_code[1] = 2'd3; e_pay[0] = '0; e_pay[1] = '0;
    e_ill = 0; e_two = 0; e_br = 0; e_tgt = '0; e_loop = 0; e_trap = 0;
    e_dcyc = 1; e_dsk = 0; e_dcf = 0;
    case (s.w[31:30])
      2'b00: begin
        e_req = "R1";
        if (s.lb) e_ill = 1; else m_issue(s, 0, 1);
      end
      2'b01, 2'b10: begin
        e_req = "R2";
        fr = (s.w[31:30] == 2'b01);
        fbad = fr ? s.rb : s.lb; fbr = fr ? s.rbr : s.lbr; sbad = fr ? s.lb : s.rb;
        if (fbad) e_ill = 1;
        else begin
          m_issue(s, fr, 0);
          if (fbr) begin e_dsk = 1; e_req = "R3"; end
          else begin
            e_two = 1;
            if (sbad) e_ill = 1;
            else begin m_issue(s, !fr, 0); e_dcyc = 2; end
          end
        end
      end
      default: begin
        if (s.lb || s.rb) e_ill = 1;
        else if (s.lt) begin
          e_req = "R4"; m_issue(s, 0, 0);
          if (s.lc) begin e_two = 1; m_issue(s, 1, 0); end else e_dcf = 1;
        end else if (s.rt) begin
          e_req = "R5"; m_issue(s, 1, 0);
          if (s.rc) begin e_two = 1; m_issue(s, 0, 0); end else e_dcf = 1;
        end else begin
          e_req = "R6"; e_two = 1; m_issue(s, 0, 0); m_issue(s, 1, 0);
        end
      end
    endcase
    if (e_ill) e_req = "R11";
    e_psw = s.psw; e_rcnt = s.rcnt;
    if (e_ill) begin e_npc = s.pc; e_preq = "R11"; end
    else if (s.den && s.pc == s.bp) begin
      e_trap = 1; e_npc = TRAP_VEC; e_psw = s.psw & SM_MASK; e_preq = "R9";
    end else if (e_br) begin e_npc = e_tgt; e_preq = "R7"; end
    else if (s.ren && s.pc == s.re) begin
      e_loop = 1; e_npc = s.rs; e_rcnt = s.rcnt - 16'd1; e_preq = "R8";
    end else begin e_npc = s.pc + 16'd1; e_preq = "R7"; end
  endtask

  task automatic run_word(stim_t s);
    logic [1:0]  a_code [2];
    logic [29:0] a_pay [2];
    int a_n, k_done;
    bit got, right;
    logic [15:0] a_npc, a_psw, a_rcnt;
    bit a_ill, a_loop, a_trap;
    logic [1:0] c;
    model(s);
    a_code[0] = 2'd3; a_code[1] = 2'd3; a_pay[0] = '0; a_pay[1] = '0;
    a_n = 0; k_done = -1; got = 0;
    a_npc = '0; a_psw = '0; a_rcnt = '0; a_ill = 0; a_loop = 0; a_trap = 0;
    @(negedge clk_i);
    ex_branch_i = 0; ex_target_i = '0; ex_cond_i = 0;
    chk(ready_o, "R12", "ready before word", 64'(ready_o), 64'd1);
    word_i = s.w; pc_i = s.pc;
    l_test_i = s.lt; r_test_i = s.rt; l_bad_i = s.lb; r_bad_i = s.rb;
    rpt_en_i = s.ren; rpt_start_i = s.rs; rpt_end_i = s.re; rpt_cnt_i = s.rcnt;
    dbg_en_i = s.den; bp_addr_i = s.bp; psw_i = s.psw;
    word_valid_i = 1;
    for (int k = 0; k < 4 && !got; k++) begin
      @(negedge clk_i);
      if (k == 0) word_valid_i = 0;
      ex_branch_i = 0; ex_target_i = '0; ex_cond_i = 0;
      if (issue_valid_o) begin
        c = issue_long_o ? 2'd2 : (issue_right_o ? 2'd1 : 2'd0);
        if (a_n < 2) begin a_code[a_n] = c; a_pay[a_n] = issue_insn_o; end
        a_n++;
        right = (c == 2'd1);
        ex_branch_i = right ? s.rbr : s.lbr;
        ex_target_i = right ? s.rtg : s.ltg;
        ex_cond_i   = right ? s.rc : s.lc;
      end
      if (done_o) begin
        got = 1; k_done = k;
        a_npc = next_pc_o; a_psw = psw_o; a_rcnt = rpt_cnt_o;
        a_ill = illegal_o; a_loop = loop_o; a_trap = trap_o;
      end
    end
    x_cyc = x_cyc + 16'(e_dcyc); x_skip = x_skip + 16'(e_dsk); x_cf = x_cf + 16'(e_dcf);
    chk(a_n == e_n && a_code[0] == e_code[0] && a_code[1] == e_code[1], e_req, "issue order",
        {32'(a_n), 28'd0, a_code[0], a_code[1]}, {32'(e_n), 28'd0, e_code[0], e_code[1]});
    for (int i = 0; i < 2; i++)
      if (i < e_n) chk(a_pay[i] == e_pay[i], "R2", "slot payload", 64'(a_pay[i]), 64'(e_pay[i]));
    chk(k_done == (e_two ? 2 : 1), "R12", "done latency", 64'(k_done), 64'(e_two ? 2 : 1));
    chk(a_ill == e_ill, "R11", "illegal flag", 64'(a_ill), 64'(e_ill));
    chk(a_npc == e_npc, e_preq, "next pc", 64'(a_npc), 64'(e_npc));
    chk(a_loop == e_loop && a_rcnt == e_rcnt, "R8", "loop/count",
        {47'd0, a_loop, a_rcnt}, {47'd0, e_loop, e_rcnt});
    chk(a_trap == e_trap && a_psw == e_psw, "R9", "trap/psw",
        {47'd0, a_trap, a_psw}, {47'd0, e_trap, e_psw});
    chk(cyc_cnt_o == x_cyc, "R10", "cycle counter", 64'(cyc_cnt_o), 64'(x_cyc));
    chk(skip_cnt_o == x_skip, "R3", "skip counter", 64'(skip_cnt_o), 64'(x_skip));
    chk(cfalse_cnt_o == x_cf, "R4", "cond-false counter", 64'(cfalse_cnt_o), 64'(x_cf));
  endtask

  function automatic stim_t mk(logic [31:0] w);
    stim_t s;
    s.w = w; s.lt = 0; s.rt = 0; s.lb = 0; s.rb = 0; s.lbr = 0; s.rbr = 0;
    s.lc = 0; s.rc = 0; s.ren = 0; s.den = 0;
    s.ltg = 16'h0A00; s.rtg = 16'h0B00; s.pc = 16'h0100; s.rs = 16'h0080;
    s.re = 16'h0200; s.rcnt = 16'd5; s.bp = 16'h0300; s.psw = 16'hFFFF;
    return s;
  endfunction

  function automatic stim_t rnd();
    stim_t s;
    s = mk($urandom);
    s.lt = ($urandom % 4) == 0; s.rt = ($urandom % 4) == 0;
    s.lb = ($urandom % 8) == 0; s.rb = ($urandom % 8) == 0;
    s.lbr = ($urandom % 4) == 0; s.rbr = ($urandom % 4) == 0;
    s.lc = $urandom % 2; s.rc = $urandom % 2;
    s.ltg = 16'($urandom); s.rtg = 16'($urandom); s.pc = 16'($urandom);
    s.rs = 16'($urandom); s.rcnt = 16'($urandom); s.psw = 16'($urandom);
    s.re = (($urandom % 3) == 0) ? s.pc : 16'($urandom);
    s.bp = (($urandom % 6) == 0) ? s.pc : 16'($urandom);
    s.ren = $urandom % 2; s.den = $urandom % 2;
    return s;
  endfunction

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    stim_t s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(ready_o && !issue_valid_o && !done_o, "R12", "reset idle",
        {61'd0, ready_o, issue_valid_o, done_o}, 64'd4);
    chk(cyc_cnt_o == 0 && skip_cnt_o == 0 && cfalse_cnt_o == 0, "R10", "reset counters",
        {16'd0, cyc_cnt_o, skip_cnt_o, cfalse_cnt_o}, 64'd0);
    rst_ni = 1;
    // R1 long with branch
    s = mk(32'h1234_5678); s.lbr = 1; run_word(s);
    // R2 right-first, no branch
    s = mk(32'h4AAA_5555); run_word(s);
    // R2 left-first
    s = mk(32'h8123_4567); run_word(s);
    // R3 left-first, first branches
    s = mk(32'h8765_4321); s.lbr = 1; s.rb = 1; run_word(s);
    // R11 right-first, second slot unknown
    s = mk(32'h4000_7FFF); s.lb = 1; run_word(s);
    // R4 left test false, then true
    s = mk(32'hC111_2222); s.lt = 1; run_word(s);
    s = mk(32'hC111_2222); s.lt = 1; s.lc = 1; s.rbr = 1; run_word(s);
    // R5 right test false; both tests -> left first
    s = mk(32'hC333_4444); s.rt = 1; run_word(s);
    s = mk(32'hC333_4444); s.lt = 1; s.rt = 1; s.lc = 1; run_word(s);
    // R6 plain parallel, left branches, right still issues
    s = mk(32'hFFFF_FFFF); s.lbr = 1; run_word(s);
    // R8 loop; branch at loop end wins
    s = mk(32'h0000_0001); s.ren = 1; s.re = s.pc; run_word(s);
    s = mk(32'h0000_0001); s.ren = 1; s.re = s.pc; s.lbr = 1; run_word(s);
    // R9 trap overrides branch and loop
    s = mk(32'h0000_0002); s.ren = 1; s.re = s.pc; s.lbr = 1; s.den = 1; s.bp = s.pc; run_word(s);
    // R11 parallel with right unknown, with trap armed
    s = mk(32'hC000_0000); s.rb = 1; s.den = 1; s.bp = s.pc; run_word(s);
    // R11 long unknown
    s = mk(32'h0000_0003); s.lb = 1; run_word(s);
    // R7 pc wrap
    s = mk(32'h0000_0004); s.pc = 16'hFFFF; run_word(s);
    for (int i = 0; i < 400; i++) run_word(rnd());
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule